// File: doc/BRIEF.md
# Set-Clear-Toggle Aliased Register Bank

This block holds 32-bit control registers behind a simple word-addressed register bus. The bus has one write strobe, one byte address, write data and a combinational read-data port. The address window has two halves, and address bit 14 picks between them.

The lower half is a small bank of plain registers. The upper half holds aliased register groups followed by more plain registers. Each aliased group takes four consecutive word indices:

- the base register;
- a SET alias, which ORs the written bits into the base;
- a CLR alias, which clears the written bits;
- a TOG alias, which inverts the written bits.

A read at any of the four indices returns the base register. This lets software change single bits without a read-modify-write sequence.

After reset every register holds a per-register default given by parameters. A chosen subset of the aliased registers also has a lock status bit forced to one. All register contents leave the block on parallel buses for downstream logic.

Top module: `scb_bank`

## Requirements
- R1: The address is a byte offset. Bit 14 selects the bank: 0 is the low plain bank and 1 is the aliased bank. The word index is address bits 13:2. An access with address bits 1:0 not zero reads 0, and a write to such an address changes nothing.
- R2: Reset is asynchronous and active low.
  - The low bank loads 0x12340000, 0x00008100 and 0x000000C3 into indices 0, 1 and 2.
  - Aliased groups 0 to 3 load 0x00002041, 0x00011000, 0x00000006 and 0x0C0C0C0C.
  - The high plain registers load 0x00000000 and 0xFFFF0000.
  - Bit 31 is then forced to 1 in groups 0, 1 and 2.
- R3: A write to index 4g of the aliased bank replaces group g's register with the write data.
- R4: A write to index 4g+1 ORs the write data into group g's register.
- R5: A write to index 4g+2 clears, in group g's register, every bit that is set in the write data. This includes the forced lock bit.
- R6: A write to index 4g+3 XORs the write data into group g's register.
- R7: A read at any index 4g to 4g+3 returns group g's register, combinationally from the current address.
- R8: Plain registers take whole-word writes. Low-bank register p sits at index p. High plain register p sits at index 16+p.
- R9: In either bank, an index that maps to no register reads 0, and a write to it changes no register.
- R10: A write becomes visible on the outputs only after the rising clock edge on which the write strobe is sampled. All registers are always presented on the parallel outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | 15 | Byte address inside the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| low_q | output | 96 | Low-bank registers, index p at bits 32p+31:32p |
| alias_q | output | 128 | Aliased group registers, group g at bits 32g+31:32g |
| plain_q | output | 64 | High plain registers, register p at bits 32p+31:32p |

## Verification
The hardest state to reach from the ports is a lock bit that software has cleared and then set again. Only a sequence of CLR, SET and TOG writes to the same group gets there; no single write does. The directed part clears the lock bit of group 0 through its CLR alias. The random part then keeps hitting the same few groups with a mix of all four write kinds, so set, clear and toggle writes pile up on one register. A bench model follows every write and compares all parallel outputs after each one.

// File: rtl/scb_pkg.sv
package scb_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  // low two bits of an aliased-bank index select the access kind
  typedef enum logic [1:0] {
    ACC_BASE = 2'd0,
    ACC_SET  = 2'd1,
    ACC_CLR  = 2'd2,
    ACC_TOG  = 2'd3
  } acc_e;

  function automatic word_t next_value(acc_e kind, word_t cur, word_t d);
    case (kind)
      ACC_SET: return cur | d;
      ACC_CLR: return cur & ~d;
      ACC_TOG: return cur ^ d;
      default: return d;
    endcase
  endfunction
endpackage

// File: rtl/scb_decode.sv
module scb_decode #(
  parameter int ADDR_W   = 15,
  parameter int NUM_LOW  = 3,
  parameter int NUM_GRP  = 4,
  parameter int NUM_HPL  = 2,
  localparam int IDX_W   = ADDR_W - 3,
  localparam int LW      = (NUM_LOW > 1) ? $clog2(NUM_LOW) : 1,
  localparam int GW      = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
  localparam int HW      = (NUM_HPL > 1) ? $clog2(NUM_HPL) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              low_hit,
  output logic [LW-1:0]     low_sel,
  output logic              grp_hit,
  output logic [GW-1:0]     grp_sel,
  output scb_pkg::acc_e     kind,
  output logic              hp_hit,
  output logic [HW-1:0]     hp_sel
);
  localparam logic [IDX_W-1:0] LOW_END = IDX_W'(NUM_LOW);
  localparam logic [IDX_W-1:0] GRP_END = IDX_W'(4 * NUM_GRP);
  localparam logic [IDX_W-1:0] HP_END  = IDX_W'(4 * NUM_GRP + NUM_HPL);

  logic [IDX_W-1:0] idx;
  logic             aligned;
  logic             upper;

  always_comb begin
    idx     = addr[ADDR_W-2:2];
    aligned = (addr[1:0] == 2'b00);
    upper   = addr[ADDR_W-1];
    low_hit = aligned && !upper && (idx < LOW_END);
    grp_hit = aligned && upper && (idx < GRP_END);
    hp_hit  = aligned && upper && (idx >= GRP_END) && (idx < HP_END);
    low_sel = LW'(idx);
    grp_sel = GW'(idx >> 2);
    kind    = scb_pkg::acc_e'(idx[1:0]);
    hp_sel  = HW'(idx - GRP_END);
  end
endmodule

// File: rtl/scb_alias_reg.sv
module scb_alias_reg #(
  parameter scb_pkg::word_t RST_VAL  = '0,
  parameter bit             LOCK_EN  = 1'b0,
  parameter int             LOCK_BIT = 31
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  scb_pkg::acc_e  kind,
  input  scb_pkg::word_t wdata,
  output scb_pkg::word_t q
);
  localparam scb_pkg::word_t LOCK_MASK = scb_pkg::word_t'(LOCK_EN) << LOCK_BIT;
  localparam scb_pkg::word_t RST_EFF   = RST_VAL | LOCK_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST_EFF;
    else if (we) q <= scb_pkg::next_value(kind, q, wdata);
  end
endmodule

// File: rtl/scb_word_reg.sv
module scb_word_reg #(
  parameter scb_pkg::word_t RST_VAL = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  scb_pkg::word_t wdata,
  output scb_pkg::word_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST_VAL;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/scb_bank.sv
module scb_bank #(
  parameter int ADDR_W   = 15,
  parameter int NUM_LOW  = 3,
  parameter int NUM_GRP  = 4,
  parameter int NUM_HPL  = 2,
  parameter int LOCK_BIT = 31,
  parameter logic [NUM_GRP-1:0]    LOCK_MASK = 4'b0111,
  parameter logic [32*NUM_LOW-1:0] LOW_RST   = {32'h0000_00C3, 32'h0000_8100, 32'h1234_0000},
  parameter logic [32*NUM_GRP-1:0] GRP_RST   = {32'h0C0C_0C0C, 32'h0000_0006,
                                                32'h0001_1000, 32'h0000_2041},
  parameter logic [32*NUM_HPL-1:0] HPL_RST   = {32'hFFFF_0000, 32'h0000_0000}
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [31:0]             wdata,
  output logic [31:0]             rdata,
  output logic [32*NUM_LOW-1:0]   low_q,
  output logic [32*NUM_GRP-1:0]   alias_q,
  output logic [32*NUM_HPL-1:0]   plain_q
);
  import scb_pkg::*;

  localparam int LW = (NUM_LOW > 1) ? $clog2(NUM_LOW) : 1;
  localparam int GW = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;
  localparam int HW = (NUM_HPL > 1) ? $clog2(NUM_HPL) : 1;

  logic          low_hit, grp_hit, hp_hit;
  logic [LW-1:0] low_sel;
  logic [GW-1:0] grp_sel;
  logic [HW-1:0] hp_sel;
  acc_e          kind;

  word_t low_a [NUM_LOW];
  word_t grp_a [NUM_GRP];
  word_t hp_a  [NUM_HPL];

  scb_decode #(
    .ADDR_W(ADDR_W), .NUM_LOW(NUM_LOW), .NUM_GRP(NUM_GRP), .NUM_HPL(NUM_HPL)
  ) u_dec (
    .addr(addr), .low_hit(low_hit), .low_sel(low_sel), .grp_hit(grp_hit),
    .grp_sel(grp_sel), .kind(kind), .hp_hit(hp_hit), .hp_sel(hp_sel)
  );

  for (genvar p = 0; p < NUM_LOW; p++) begin : g_low
    scb_word_reg #(.RST_VAL(LOW_RST[32*p +: 32])) u_reg (
      .clk(clk), .rst_n(rst_n),
      .we(wr_en && low_hit && (low_sel == LW'(p))),
      .wdata(wdata), .q(low_a[p])
    );
    assign low_q[32*p +: 32] = low_a[p];
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    scb_alias_reg #(
      .RST_VAL(GRP_RST[32*g +: 32]), .LOCK_EN(LOCK_MASK[g]), .LOCK_BIT(LOCK_BIT)
    ) u_reg (
      .clk(clk), .rst_n(rst_n),
      .we(wr_en && grp_hit && (grp_sel == GW'(g))),
      .kind(kind), .wdata(wdata), .q(grp_a[g])
    );
    assign alias_q[32*g +: 32] = grp_a[g];
  end

  for (genvar p = 0; p < NUM_HPL; p++) begin : g_hpl
    scb_word_reg #(.RST_VAL(HPL_RST[32*p +: 32])) u_reg (
      .clk(clk), .rst_n(rst_n),
      .we(wr_en && hp_hit && (hp_sel == HW'(p))),
      .wdata(wdata), .q(hp_a[p])
    );
    assign plain_q[32*p +: 32] = hp_a[p];
  end

  // every alias of a group reads its base register
  always_comb begin
    rdata = '0;
    if (low_hit)      rdata = low_a[low_sel];
    else if (grp_hit) rdata = grp_a[grp_sel];
    else if (hp_hit)  rdata = hp_a[hp_sel];
  end
endmodule

// File: rtl/scb_bank_chk.sv
module scb_bank_chk #(
  parameter int ADDR_W   = 15,
  parameter int NUM_LOW  = 3,
  parameter int NUM_GRP  = 4,
  parameter int NUM_HPL  = 2,
  parameter int LOCK_BIT = 31,
  parameter logic [NUM_GRP-1:0] LOCK_MASK = 4'b0111
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [ADDR_W-1:0]     addr,
  input logic [31:0]           wdata,
  input logic [31:0]           rdata,
  input logic [32*NUM_LOW-1:0] low_q,
  input logic [32*NUM_GRP-1:0] alias_q,
  input logic [32*NUM_HPL-1:0] plain_q
);
  localparam int IDX_W = ADDR_W - 3;

  logic [IDX_W-1:0] c_idx;
  logic c_al, c_hi, c_mapped;
  assign c_idx = addr[ADDR_W-2:2];
  assign c_al  = (addr[1:0] == 2'b00);
  assign c_hi  = addr[ADDR_W-1];
  assign c_mapped = c_al && (c_hi ? (c_idx < IDX_W'(4*NUM_GRP + NUM_HPL))
                                  : (c_idx < IDX_W'(NUM_LOW)));

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_chk
    // R3
    a_r3_base_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && c_al && c_hi && c_idx == IDX_W'(4*g))
      |=> alias_q[32*g +: 32] == $past(wdata));
    // R4
    a_r4_set_or: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && c_al && c_hi && c_idx == IDX_W'(4*g+1))
      |=> alias_q[32*g +: 32] == ($past(alias_q[32*g +: 32]) | $past(wdata)));
    // R5
    a_r5_clr_andn: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && c_al && c_hi && c_idx == IDX_W'(4*g+2))
      |=> alias_q[32*g +: 32] == ($past(alias_q[32*g +: 32]) & ~$past(wdata)));
    // R6
    a_r6_tog_xor: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && c_al && c_hi && c_idx == IDX_W'(4*g+3))
      |=> alias_q[32*g +: 32] == ($past(alias_q[32*g +: 32]) ^ $past(wdata)));
    // R7
    a_r7_alias_read: assert property (@(posedge clk) disable iff (!rst_n)
      (c_al && c_hi && (c_idx >> 2) == IDX_W'(g)) |-> rdata == alias_q[32*g +: 32]);
    if (LOCK_MASK[g]) begin : g_lock
      // R2
      a_r2_lock_after_reset: assert property (@(posedge clk)
        !rst_n |=> alias_q[32*g + LOCK_BIT]);
    end
  end

  // R9
  a_r9_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !c_mapped) |=> ($stable(low_q) && $stable(alias_q) && $stable(plain_q)));
  // R9
  a_r9_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
    !c_mapped |-> rdata == 32'h0);
  // R10
  a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(low_q) && $stable(alias_q) && $stable(plain_q)));
endmodule

bind scb_bank scb_bank_chk #(
  .ADDR_W(ADDR_W), .NUM_LOW(NUM_LOW), .NUM_GRP(NUM_GRP), .NUM_HPL(NUM_HPL),
  .LOCK_BIT(LOCK_BIT), .LOCK_MASK(LOCK_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .low_q(low_q), .alias_q(alias_q), .plain_q(plain_q)
);

// File: tb/sim_scb_bank.sv
`timescale 1ns/1ps
module sim_scb_bank;
  localparam int NL = 3;
  localparam int NG = 4;
  localparam int NH = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [14:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [32*NL-1:0] low_q;
  logic [32*NG-1:0] alias_q;
  logic [32*NH-1:0] plain_q;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [31:0] m_low [NL];
  logic [31:0] m_grp [NG];
  logic [31:0] m_hp  [NH];

  scb_bank u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .low_q(low_q), .alias_q(alias_q), .plain_q(plain_q)
  );

  always #2 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_low[0] = 32'h1234_0000; m_low[1] = 32'h0000_8100; m_low[2] = 32'h0000_00C3;
    m_grp[0] = 32'h8000_2041; m_grp[1] = 32'h8001_1000;
    m_grp[2] = 32'h8000_0006; m_grp[3] = 32'h0C0C_0C0C;
    m_hp[0]  = 32'h0000_0000; m_hp[1]  = 32'hFFFF_0000;
  endtask

  function automatic logic [31:0] model_read(logic [14:0] a);
    int idx = int'(a[13:2]);
    if (a[1:0] != 2'b00) return 32'h0;
    if (!a[14]) return (idx < NL) ? m_low[idx] : 32'h0;
    if (idx < 4*NG) return m_grp[idx/4];
    if (idx < 4*NG + NH) return m_hp[idx - 4*NG];
    return 32'h0;
  endfunction

  function automatic string tag_for(logic [14:0] a);
    int idx = int'(a[13:2]);
    if (a[1:0] != 2'b00) return "R1";
    if (!a[14]) return (idx < NL) ? "R8" : "R9";
    if (idx < 4*NG) begin
      case (idx % 4)
        0: return "R3";
        1: return "R4";
        2: return "R5";
        default: return "R6";
      endcase
    end
    if (idx < 4*NG + NH) return "R8";
    return "R9";
  endfunction

  task automatic model_write(logic [14:0] a, logic [31:0] d);
    int idx = int'(a[13:2]);
    if (a[1:0] != 2'b00) return;
    if (!a[14]) begin
      if (idx < NL) m_low[idx] = d;
    end else if (idx < 4*NG) begin
      case (idx % 4)
        0: m_grp[idx/4] = d;
        1: m_grp[idx/4] = m_grp[idx/4] | d;
        2: m_grp[idx/4] = m_grp[idx/4] & ~d;
        default: m_grp[idx/4] = m_grp[idx/4] ^ d;
      endcase
    end else if (idx < 4*NG + NH) begin
      m_hp[idx - 4*NG] = d;
    end
  endtask

  task automatic chk_all(string req);
    for (int i = 0; i < NL; i++) chk(req, low_q[32*i +: 32], m_low[i]);
    for (int i = 0; i < NG; i++) chk(req, alias_q[32*i +: 32], m_grp[i]);
    for (int i = 0; i < NH; i++) chk(req, plain_q[32*i +: 32], m_hp[i]);
  endtask

  task automatic do_write(logic [14:0] a, logic [31:0] d);
    string req = tag_for(a);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    #1 chk_all("R10");                    // nothing changes before the edge
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
    chk_all(req);
    chk(req, rdata, model_read(a));
  endtask

  task automatic do_read(logic [14:0] a, string req);
    @(negedge clk);
    addr = a;
    #1 chk(req, rdata, model_read(a));
  endtask

  function automatic logic [14:0] hi_addr(int idx);
    return 15'h4000 | 15'(idx << 2);
  endfunction

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    #1 chk_all("R2");                     // values held during reset
    rst_n = 1'b1;
    @(negedge clk);
    #1 chk_all("R2");
    // R7: each alias of group 0 and group 2 reads the base
    for (int k = 0; k < 4; k++) do_read(hi_addr(k), "R7");
    for (int k = 8; k < 12; k++) do_read(hi_addr(k), "R7");
    do_write(hi_addr(5), 32'h00F0_0000);   // R4 set on group 1
    do_write(hi_addr(2), 32'h8000_0001);   // R5 clears lock bit of group 0
    chk("R5", alias_q[31:0], 32'h0000_2040);
    do_write(hi_addr(1), 32'h8000_0000);   // R4 lock bit set again
    do_write(hi_addr(11), 32'hFFFF_FFFF);  // R6 toggle all of group 2
    chk("R6", alias_q[95:64], 32'h7FFF_FFF9);
    do_write(hi_addr(12), 32'hA5A5_5A5A);  // R3 base replace
    do_write(hi_addr(16), 32'hDEAD_BEEF);  // R8 high plain
    do_write(15'h0004, 32'h0BAD_F00D);     // R8 low bank, R1 bank select
    do_write(15'h4001, 32'hFFFF_FFFF);     // R1 misaligned write ignored
    do_read(15'h4006, "R1");
    do_write(hi_addr(18), 32'h1111_1111);  // R9 unmapped high
    do_write(15'h000C, 32'h2222_2222);     // R9 unmapped low
    do_write(15'h7000, 32'h3333_3333);     // R9 far index
    do_read(15'h0C00, "R9");
    for (int n = 0; n < 600; n++) begin
      int sel = int'($urandom % 10);
      logic [14:0] a;
      if (sel < 5)       a = hi_addr(int'($urandom % 8));        // groups 0,1 hammered
      else if (sel < 7)  a = hi_addr(int'($urandom % 20));
      else if (sel < 9)  a = 15'(($urandom % 5) << 2);
      else               a = 15'($urandom);
      if (($urandom % 4) == 0) do_read(a, tag_for(a) == "R3" ? "R7" : tag_for(a));
      else do_write(a, $urandom);
    end
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    #1 chk_all("R2");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1 chk_all("R2");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule